// File: doc/BRIEF.md
# BCD Calendar Clock with Holding-Register Snapshot

This block counts seconds, minutes, hours, day of week, date, month and two-digit year in packed BCD. It advances once for each pulse on a one-per-second enable, which a separate prescaler supplies. The seconds-to-years carry chain settles within the tick cycle, and month lengths and leap years are handled without help from software.

A host reaches the clock through an eight-byte window. A control byte sits at offset 0, and the seven time fields occupy offsets 1 to 7, from seconds up to year. The host never touches the live counters directly. It reads and writes a set of holding registers, which take a copy of the counters on each tick. Two bits in the control byte freeze that copy. The read-halt bit gives the host a stable snapshot while the counters keep running. The write-halt bit lets the host load a new time, and when the host clears that bit, all fields are transferred into the counters in one cycle. A stop flag in the seconds location halts counting. The control byte also stores a calibration magnitude and sign, which go straight to the external calibration block.

Top module: `rtc_calendar_snap`

## Requirements
- R1: After reset the window reads as follows: offset 0 = 0x00, offset 1 = 0x80 (stop set, seconds 00), minutes 00, hours 00, day of week 01, date 01, month 01, year 00.
- R2: While the stop flag (bit 7 at offset 1) is 1, ticks leave the time unchanged. After a write clears it, the first later tick advances the seconds.
- R3: When neither halt bit is set, a tick updates all seven holding registers together with the advanced time. The new values are readable in the cycle after the tick.
- R4: On a single tick the time carries through every field: seconds 59→00, minutes 59→00, hours 23→00, day of week 7→1, and year 99→00.
- R5: The date wraps to 01 after day 31 of months 01, 03, 05, 07, 08, 10 and 12, after day 30 of months 04, 06, 09 and 11, and after day 29 of month 02 in years divisible by 4 (00 counts as one). In other years month 02 wraps after day 28.
- R6: While control bit 6 (read halt) is 1, ticks do not change the holding registers, but the live counters keep advancing. After the bit is cleared, the next tick shows the advanced time.
- R7: While control bit 7 (write halt) is 1, the holding registers are frozen and can be written. A control write that clears bit 7 copies every holding register into the counters. A tick in that same cycle is dropped, and the next advance comes on the following tick.
- R8: A control write that sets a halt bit in the same cycle as a tick does not block that tick's refresh.
- R9: A write to a time field while no halt bit is set changes only the holding register, and the next refresh overwrites it. If the write lands in the same cycle as a refresh, the refresh value wins.
- R10: Unused bits read as 0 and cannot be written: minutes and seconds bit 7 (seconds bit 7 is the stop flag), hours bits 7:6, day bits 7:3 (bit 6 is a frequency-test flag that always reads 0), date bits 7:6, and month bits 7:5.
- R11: Control bits 4:0 appear on `cal_magnitude` and control bit 5 on `cal_speedup`. The whole control byte reads back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sec_tick | input | 1 | One-cycle pulse once per second |
| host_sel | input | 1 | Host access strobe |
| host_wr | input | 1 | Write qualifier for host_sel |
| host_addr | input | 3 | Window offset (0 control, 1 sec ... 7 year) |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data for host_addr (combinational) |
| cal_magnitude | output | 5 | Calibration magnitude |
| cal_speedup | output | 1 | Calibration sign, 1 = speed up |

## Verification
The bench targets the full carry from 23:59:59 on 31 December 99, and every month-end including February in leap and non-leap years. A wrong month-length table or a broken carry would show up as an illegal date or a stuck field. It also drives the same-cycle collisions: a tick together with a halt write, a tick together with a commit, and a tick together with a host write. A design with the wrong priority would cut a refresh short, advance twice after a commit, or keep a stale host value. Read-halt sequences check that the counters really keep running behind a frozen snapshot. The stop-flag test catches a design that starts counting before the next tick.

// File: rtl/rtc_snap_pkg.sv
// Shared constants, types and field tables for the BCD calendar clock.
// Assumes seven time fields, each held as one packed BCD byte, and places
// field i at window offset i+1 with the control byte at offset 0.
package rtc_snap_pkg;

    localparam int NUM_FIELDS = 7;
    localparam int ADDR_W     = $clog2(NUM_FIELDS + 1);
    localparam int BYTE_W     = 8;
    localparam int CAL_W      = 5;

    // Field indices (low to high significance of the carry chain)
    localparam int F_SEC   = 0;
    localparam int F_MIN   = 1;
    localparam int F_HOUR  = 2;
    localparam int F_DOW   = 3;
    localparam int F_DATE  = 4;
    localparam int F_MONTH = 5;
    localparam int F_YEAR  = 6;

    // Control byte bit positions
    localparam int CTRL_WR_BIT   = 7;
    localparam int CTRL_RD_BIT   = 6;
    localparam int CTRL_SIGN_BIT = 5;
    // Stop flag position inside the seconds location
    localparam int STOP_BIT      = 7;

    typedef logic [NUM_FIELDS-1:0][BYTE_W-1:0] time_vec_t;

    // Bits that exist in each field
    function automatic logic [BYTE_W-1:0] field_mask(input int idx);
        case (idx)
            F_SEC, F_MIN: return 8'h7F;
            F_HOUR:       return 8'h3F;
            F_DOW:        return 8'h07;
            F_DATE:       return 8'h3F;
            F_MONTH:      return 8'h1F;
            default:      return 8'hFF;
        endcase
    endfunction

    // Value each field wraps to (also its reset value)
    function automatic logic [BYTE_W-1:0] field_low(input int idx);
        case (idx)
            F_DOW, F_DATE, F_MONTH: return 8'h01;
            default:                return 8'h00;
        endcase
    endfunction

    // Highest value of each field (date is overridden by the month table)
    function automatic logic [BYTE_W-1:0] field_high(input int idx);
        case (idx)
            F_SEC, F_MIN: return 8'h59;
            F_HOUR:       return 8'h23;
            F_DOW:        return 8'h07;
            F_DATE:       return 8'h31;
            F_MONTH:      return 8'h12;
            default:      return 8'h99;
        endcase
    endfunction

    // Field whose wrap increments this field; -1 means the tick itself
    function automatic int field_parent(input int idx);
        case (idx)
            F_SEC:          return -1;
            F_MIN:          return F_SEC;
            F_HOUR:         return F_MIN;
            F_DOW, F_DATE:  return F_HOUR;
            F_MONTH:        return F_DATE;
            default:        return F_MONTH;
        endcase
    endfunction

    // Last date of a month in BCD; years divisible by four are leap years
    function automatic logic [BYTE_W-1:0] days_in_month(input logic [BYTE_W-1:0] mon,
                                                        input logic [BYTE_W-1:0] yr);
        logic leap;
        leap = yr[4] ? (yr[3:0] == 4'd2 || yr[3:0] == 4'd6)
                     : (yr[3:0] == 4'd0 || yr[3:0] == 4'd4 || yr[3:0] == 4'd8);
        case (mon)
            8'h02:                      return leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_bcd_step.sv
// One packed-BCD digit pair with wrap.
// Combinational. When inc is high the value steps by one. At or above 'high'
// it returns LOW and raises wrap. Using >= rather than == keeps a loaded
// out-of-range value from running away. Assumes each nibble holds a BCD digit.
module rtc_bcd_step #(
    parameter logic [7:0] LOW = 8'h00
) (
    input  logic [7:0] cur,
    input  logic [7:0] high,
    input  logic       inc,
    output logic [7:0] nxt,
    output logic       wrap
);

    // Next value and wrap flag for one field
    always_comb begin
        wrap = inc && (cur >= high);
        if (!inc) begin
            nxt = cur;
        end else if (cur >= high) begin
            nxt = LOW;
        end else if (cur[3:0] >= 4'd9) begin
            nxt = {cur[7:4] + 4'd1, 4'd0};
        end else begin
            nxt = {cur[7:4], cur[3:0] + 4'd1};
        end
    end

endmodule

// File: rtl/rtc_time_advance.sv
// Full calendar advance across all seven fields, combinational.
// With step high it returns the time one second later. The whole carry path
// (seconds to year, plus day of week) resolves in one cycle. With step low
// the output equals the input. Assumes the input fields hold BCD.
module rtc_time_advance
    import rtc_snap_pkg::*;
(
    input  time_vec_t cur,
    input  logic      step,
    output time_vec_t nxt
);

    logic [NUM_FIELDS-1:0] inc;
    logic [NUM_FIELDS-1:0] wrap;
    logic [BYTE_W-1:0]     month_end;
    logic                  wrap_unused;

    assign month_end   = days_in_month(cur[F_MONTH], cur[F_YEAR]);
    assign wrap_unused = wrap[F_DOW] ^ wrap[F_YEAR];

    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_fld
        localparam int PAR = field_parent(i);
        logic [BYTE_W-1:0] high;

        if (PAR < 0) begin : g_root
            assign inc[i] = step;
        end else begin : g_child
            assign inc[i] = wrap[PAR];
        end

        if (i == F_DATE) begin : g_date
            assign high = month_end;
        end else begin : g_fixed
            assign high = field_high(i);
        end

        rtc_bcd_step #(
            .LOW(field_low(i))
        ) u_step (
            .cur (cur[i]),
            .high(high),
            .inc (inc[i]),
            .nxt (nxt[i]),
            .wrap(wrap[i])
        );
    end

endmodule

// File: rtl/rtc_host_regs.sv
// Host-facing register window: control byte, stop flag and seven holding
// registers. A refresh takes priority over a host write to the same field.
// Unused bits are never stored. Commit pulses when a control write clears a
// write-halt bit that was set. Assumes 'refresh' is only raised when no halt
// bit is set.
module rtc_host_regs
    import rtc_snap_pkg::*;
#(
    parameter logic STOP_AT_RESET = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_sel,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [BYTE_W-1:0] host_wdata,
    output logic [BYTE_W-1:0] host_rdata,
    input  logic              refresh,
    input  time_vec_t         refresh_val,
    output time_vec_t         hold_q,
    output logic [BYTE_W-1:0] ctrl_q,
    output logic              stop_q,
    output logic              commit
);

    logic wr_ev;

    assign wr_ev  = host_sel && host_wr;
    assign commit = wr_ev && (host_addr == '0) && ctrl_q[CTRL_WR_BIT]
                    && !host_wdata[CTRL_WR_BIT];

    // Control byte storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_ev && host_addr == '0) begin
            ctrl_q <= host_wdata;
        end
    end

    // Stop flag storage, written through the seconds location
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stop_q <= STOP_AT_RESET;
        end else if (wr_ev && host_addr == ADDR_W'(F_SEC + 1)) begin
            stop_q <= host_wdata[STOP_BIT];
        end
    end

    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_hold
        localparam logic [BYTE_W-1:0] MASK = field_mask(i);

        // Holding register: refresh first, then masked host write
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hold_q[i] <= field_low(i);
            end else if (refresh) begin
                hold_q[i] <= refresh_val[i] & MASK;
            end else if (wr_ev && host_addr == ADDR_W'(i + 1)) begin
                hold_q[i] <= host_wdata & MASK;
            end
        end
    end

    // Read multiplexer over the window
    always_comb begin
        host_rdata = ctrl_q;
        for (int i = 0; i < NUM_FIELDS; i++) begin
            if (host_addr == ADDR_W'(i + 1)) begin
                host_rdata = hold_q[i];
            end
        end
        if (host_addr == ADDR_W'(F_SEC + 1)) begin
            host_rdata[STOP_BIT] = stop_q;
        end
    end

    AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        ((ctrl_q[CTRL_WR_BIT] || ctrl_q[CTRL_RD_BIT]) && !(wr_ev && host_addr != '0))
        |=> $stable(hold_q)); // R6

    AST_DOW_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (host_addr == ADDR_W'(F_DOW + 1)) |-> (host_rdata[7:3] == 5'd0)); // R10

endmodule

// File: rtl/rtc_calendar_snap.sv
// Top: BCD calendar clock whose live counters sit behind a host-visible
// snapshot. The counters advance on sec_tick unless stopped. A commit loads
// them from the holding registers and wins over a tick in the same cycle.
// The snapshot refreshes on each tick while neither halt bit is set.
// Assumes sec_tick is a one-cycle pulse in the clk domain.
module rtc_calendar_snap
    import rtc_snap_pkg::*;
#(
    parameter logic STOP_AT_RESET = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_tick,
    input  logic              host_sel,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [BYTE_W-1:0] host_wdata,
    output logic [BYTE_W-1:0] host_rdata,
    output logic [CAL_W-1:0]  cal_magnitude,
    output logic              cal_speedup
);

    time_vec_t         live_q;
    time_vec_t         adv;
    time_vec_t         hold;
    logic [BYTE_W-1:0] ctrl;
    logic              stop;
    logic              commit;
    logic              step;
    logic              refresh;

    assign step    = sec_tick && !stop;
    assign refresh = sec_tick && !ctrl[CTRL_WR_BIT] && !ctrl[CTRL_RD_BIT];

    assign cal_magnitude = ctrl[CAL_W-1:0];
    assign cal_speedup   = ctrl[CTRL_SIGN_BIT];

    rtc_time_advance u_adv (
        .cur (live_q),
        .step(step),
        .nxt (adv)
    );

    rtc_host_regs #(
        .STOP_AT_RESET(STOP_AT_RESET)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_sel   (host_sel),
        .host_wr    (host_wr),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .refresh    (refresh),
        .refresh_val(adv),
        .hold_q     (hold),
        .ctrl_q     (ctrl),
        .stop_q     (stop),
        .commit     (commit)
    );

    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_live
        // Live counter field: commit load, else one-second advance
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                live_q[i] <= field_low(i);
            end else if (commit) begin
                live_q[i] <= hold[i];
            end else begin
                live_q[i] <= adv[i];
            end
        end
    end

    AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && !commit) |=> $stable(live_q)); // R2

    AST_REFRESH_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        refresh |=> (hold == live_q)); // R3

    AST_SEC_ROLL: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && !stop && !commit && live_q[F_SEC] == 8'h59)
        |=> (live_q[F_SEC] == 8'h00)); // R4

    AST_COMMIT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (live_q == $past(hold))); // R7

endmodule

// File: tb/rtc_calendar_snap_tb.sv
`timescale 1ns/1ps
module rtc_calendar_snap_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sec_tick = 1'b0;
    logic       host_sel = 1'b0;
    logic       host_wr = 1'b0;
    logic [2:0] host_addr = 3'd0;
    logic [7:0] host_wdata = 8'd0;
    logic [7:0] host_rdata;
    logic [4:0] cal_magnitude;
    logic       cal_speedup;

    int    checks = 0;
    int    fails  = 0;
    string phase  = "R1 reset";

    always #2 clk = ~clk;

    rtc_calendar_snap u_dut (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
        .host_sel(host_sel), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .cal_magnitude(cal_magnitude), .cal_speedup(cal_speedup)
    );

    // ---------------- behavioural reference model ----------------
    int         m_cnt [7];
    logic [7:0] m_hold[7];
    logic [7:0] m_ctrl;
    logic       m_stop;
    localparam logic [7:0] MSK[7] = '{8'h7F, 8'h7F, 8'h3F, 8'h07, 8'h3F, 8'h1F, 8'hFF};

    function automatic int bcd2int(logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    function automatic logic [7:0] int2bcd(int v);
        logic [7:0] r;
        r[7:4] = 4'(v / 10);
        r[3:0] = 4'(v % 10);
        return r;
    endfunction

    function automatic int mdays(int mo, int y);
        if (mo == 2) return (y % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    function automatic logic [7:0] model_read(int a);
        if (a == 0) return m_ctrl;
        if (a == 1) return {m_stop, m_hold[0][6:0]};
        return m_hold[a-1];
    endfunction

    always @(posedge clk) begin : model
        int         n [7];
        logic [7:0] nh[7];
        logic       wev, step, refresh, commit;
        if (!rst_n) begin
            m_cnt  = '{0, 0, 0, 1, 1, 1, 0};
            m_hold = '{8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00};
            m_ctrl = 8'h00;
            m_stop = 1'b1;
        end else begin
            wev     = host_sel && host_wr;
            step    = sec_tick && !m_stop;
            refresh = sec_tick && !m_ctrl[7] && !m_ctrl[6];
            commit  = wev && host_addr == 3'd0 && m_ctrl[7] && !host_wdata[7];
            n = m_cnt;
            if (step) begin
                n[0]++;
                if (n[0] == 60) begin
                    n[0] = 0; n[1]++;
                    if (n[1] == 60) begin
                        n[1] = 0; n[2]++;
                        if (n[2] == 24) begin
                            n[2] = 0;
                            n[3] = (n[3] == 7) ? 1 : n[3] + 1;
                            n[4]++;
                            if (n[4] > mdays(n[5], n[6])) begin
                                n[4] = 1; n[5]++;
                                if (n[5] > 12) begin
                                    n[5] = 1;
                                    n[6] = (n[6] + 1) % 100;
                                end
                            end
                        end
                    end
                end
            end
            nh = m_hold;
            if (wev && host_addr != 3'd0)
                nh[int'(host_addr) - 1] = host_wdata & MSK[int'(host_addr) - 1];
            if (refresh)
                for (int i = 0; i < 7; i++) nh[i] = int2bcd(n[i]);
            if (commit)
                for (int i = 0; i < 7; i++) m_cnt[i] = bcd2int(m_hold[i]);
            else
                m_cnt = n;
            if (wev && host_addr == 3'd0) m_ctrl = host_wdata;
            if (wev && host_addr == 3'd1) m_stop = host_wdata[7];
            m_hold = nh;
        end
    end

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    // Per-cycle comparison against the model, away from the clock edge
    always @(posedge clk) begin
        #1;
        if (rst_n)
            chk({phase, " (model)"}, {18'd0, cal_speedup, cal_magnitude, host_rdata},
                {18'd0, m_ctrl[5], m_ctrl[4:0], model_read(int'(host_addr))});
    end

    // ---------------- stimulus helpers ----------------
    task automatic cyc(logic t, logic w, logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        sec_tick = t; host_sel = w; host_wr = w; host_addr = a; host_wdata = d;
    endtask

    task automatic expect_reg(logic [2:0] a, logic [7:0] exp, string tag);
        @(negedge clk);
        sec_tick = 1'b0; host_sel = 1'b0; host_wr = 1'b0; host_addr = a;
        #1;
        chk(tag, {24'd0, host_rdata}, {24'd0, exp});
    endtask

    task automatic load(logic [7:0] y, logic [7:0] mo, logic [7:0] d, logic [7:0] dw,
                        logic [7:0] h, logic [7:0] mi, logic [7:0] s);
        cyc(0, 1, 3'd0, 8'h80);
        cyc(0, 1, 3'd7, y);
        cyc(0, 1, 3'd6, mo);
        cyc(0, 1, 3'd5, d);
        cyc(0, 1, 3'd4, dw);
        cyc(0, 1, 3'd3, h);
        cyc(0, 1, 3'd2, mi);
        cyc(0, 1, 3'd1, s);
        cyc(0, 1, 3'd0, 8'h00);
    endtask

    task automatic tick();
        cyc(1, 0, 3'd0, 8'h00);
    endtask

    initial begin : watchdog
        #(4 * 200000);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not complete (all requirements)");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        phase = "R1 reset";
        expect_reg(3'd0, 8'h00, "R1 ctrl");
        expect_reg(3'd1, 8'h80, "R1 seconds/stop");
        expect_reg(3'd2, 8'h00, "R1 minutes");
        expect_reg(3'd3, 8'h00, "R1 hours");
        expect_reg(3'd4, 8'h01, "R1 day");
        expect_reg(3'd5, 8'h01, "R1 date");
        expect_reg(3'd6, 8'h01, "R1 month");
        expect_reg(3'd7, 8'h00, "R1 year");

        // R2 stop flag
        phase = "R2 stop";
        tick(); tick(); tick();
        expect_reg(3'd1, 8'h80, "R2 stopped");
        cyc(0, 1, 3'd1, 8'h00);
        tick();
        expect_reg(3'd1, 8'h01, "R2 resume on next tick");

        // R4 full carry
        phase = "R4 carry";
        load(8'h99, 8'h12, 8'h31, 8'h07, 8'h23, 8'h59, 8'h59);
        tick();
        expect_reg(3'd7, 8'h00, "R4 year wrap");
        expect_reg(3'd6, 8'h01, "R4 month wrap");
        expect_reg(3'd5, 8'h01, "R4 date wrap");
        expect_reg(3'd4, 8'h01, "R4 day wrap");
        expect_reg(3'd3, 8'h00, "R4 hour wrap");
        expect_reg(3'd2, 8'h00, "R4 minute wrap");
        expect_reg(3'd1, 8'h00, "R3 R4 second wrap");

        // R5 month lengths
        phase = "R5 month end";
        load(8'h24, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59); tick();
        expect_reg(3'd5, 8'h29, "R5 leap feb 29");
        load(8'h23, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59); tick();
        expect_reg(3'd5, 8'h01, "R5 feb 28 wrap");
        expect_reg(3'd6, 8'h03, "R5 to march");
        load(8'h24, 8'h02, 8'h29, 8'h03, 8'h23, 8'h59, 8'h59); tick();
        expect_reg(3'd6, 8'h03, "R5 leap feb 29 wrap");
        load(8'h00, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59); tick();
        expect_reg(3'd5, 8'h29, "R5 year 00 leap");
        load(8'h21, 8'h04, 8'h30, 8'h03, 8'h23, 8'h59, 8'h59); tick();
        expect_reg(3'd6, 8'h05, "R5 april 30");
        load(8'h21, 8'h01, 8'h31, 8'h03, 8'h23, 8'h59, 8'h59); tick();
        expect_reg(3'd6, 8'h02, "R5 january 31");

        // R6 read halt
        phase = "R6 read halt";
        load(8'h21, 8'h06, 8'h15, 8'h02, 8'h10, 8'h00, 8'h00);
        cyc(0, 1, 3'd0, 8'h40);
        tick(); tick(); tick();
        expect_reg(3'd1, 8'h00, "R6 frozen seconds");
        expect_reg(3'd3, 8'h10, "R6 frozen hours");
        cyc(0, 1, 3'd0, 8'h00);
        expect_reg(3'd1, 8'h00, "R6 no refresh before tick");
        tick();
        expect_reg(3'd1, 8'h04, "R6 counters kept running");

        // R7 write halt and commit
        phase = "R7 write halt";
        cyc(0, 1, 3'd0, 8'h80);
        cyc(0, 1, 3'd2, 8'h30);
        tick();
        expect_reg(3'd2, 8'h30, "R7 loaded minutes held");
        expect_reg(3'd1, 8'h04, "R7 frozen seconds");
        cyc(1, 1, 3'd0, 8'h00);
        expect_reg(3'd1, 8'h04, "R7 commit drops tick");
        tick();
        expect_reg(3'd1, 8'h05, "R7 advance after commit");
        expect_reg(3'd2, 8'h30, "R7 committed minutes");

        // R8 halt arriving with a tick
        phase = "R8 halt at refresh";
        cyc(1, 1, 3'd0, 8'h40);
        expect_reg(3'd1, 8'h06, "R8 refresh completed");
        tick();
        expect_reg(3'd1, 8'h06, "R8 halted afterwards");
        cyc(0, 1, 3'd0, 8'h00);
        tick();
        expect_reg(3'd1, 8'h08, "R8 release");

        // R9 writes without halt
        phase = "R9 unhalted write";
        cyc(0, 1, 3'd2, 8'h45);
        expect_reg(3'd2, 8'h45, "R9 holding written");
        tick();
        expect_reg(3'd2, 8'h30, "R9 overwritten by refresh");
        expect_reg(3'd1, 8'h09, "R9 seconds");
        cyc(1, 1, 3'd2, 8'h11);
        expect_reg(3'd2, 8'h30, "R9 refresh wins same cycle");
        expect_reg(3'd1, 8'h10, "R9 seconds carry digit");

        // R10 unused bits
        phase = "R10 unused bits";
        cyc(0, 1, 3'd2, 8'hFF); expect_reg(3'd2, 8'h7F, "R10 minutes pad");
        cyc(0, 1, 3'd3, 8'hFF); expect_reg(3'd3, 8'h3F, "R10 hours pad");
        cyc(0, 1, 3'd4, 8'hFF); expect_reg(3'd4, 8'h07, "R10 day pad and test flag");
        cyc(0, 1, 3'd5, 8'hFF); expect_reg(3'd5, 8'h3F, "R10 date pad");
        cyc(0, 1, 3'd6, 8'hFF); expect_reg(3'd6, 8'h1F, "R10 month pad");
        tick();
        expect_reg(3'd2, 8'h30, "R10 restored by refresh");

        // R11 calibration storage
        phase = "R11 calibration";
        cyc(0, 1, 3'd0, 8'h3F);
        expect_reg(3'd0, 8'h3F, "R11 ctrl readback");
        chk("R11 cal outputs", {26'd0, cal_speedup, cal_magnitude}, {26'd0, 1'b1, 5'h1F});
        cyc(0, 1, 3'd0, 8'h0A);
        expect_reg(3'd0, 8'h0A, "R11 ctrl readback 2");
        chk("R11 cal outputs 2", {26'd0, cal_speedup, cal_magnitude}, {26'd0, 1'b0, 5'h0A});

        // R5 R4 sweep of month ends against the model
        phase = "R5 R4 R6 sweep";
        for (int k = 0; k < 300; k++) begin
            int y, mo, d, dw;
            logic hold_read;
            y  = int'($urandom % 100);
            mo = 1 + int'($urandom % 12);
            d  = mdays(mo, y) - int'($urandom % 2);
            dw = 1 + int'($urandom % 7);
            hold_read = ($urandom % 3) == 0;
            load(int2bcd(y), int2bcd(mo), int2bcd(d), int2bcd(dw), 8'h23, 8'h59, 8'h58);
            if (hold_read) cyc(0, 1, 3'd0, 8'h40);
            tick(); tick();
            if (hold_read) begin
                cyc(0, 1, 3'd0, 8'h00);
                tick();
            end
            for (int a = 1; a < 8; a++) begin
                @(negedge clk);
                sec_tick = 1'b0; host_sel = 1'b0; host_wr = 1'b0; host_addr = 3'(a);
            end
        end

        @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule